// File: doc/BRIEF.md
# Serial Channel Transmit Path

This block is the transmit half of one asynchronous serial channel. Characters are written into a normal transmit queue. A small priority queue takes precedence over it. A one-byte holding stage sits between the queues and the shift register, and the shift register drives the serial line. Two control bytes and a 16-bit rate divisor are written through a small register port, selected by `reg_sel`. Those settings choose the character format, the line-control outputs and the bit rate.

Software uses the priority queue for urgent characters, such as flow-control bytes. They overtake anything already waiting in the normal queue. The transmit enable gates only the step from the queues into the holding stage. After the enable is cleared, the character in the shift register and the character in the holding stage still go out. Nothing else leaves after that. The status outputs tell software when the queue and the shifting stages are empty.

Top module: `sertx_path`

## Requirements
- R1: After reset, `txd` and `loop_out` are high, `dtr` and `rts` are low, `txq_empty`, `shreg_empty` and `drained` are high, and `txq_full`, `prio_full` and `prio_pend` are low. All control registers reset to zero.
- R2: The format byte is written with `reg_sel`=0. Each character is sent as follows:
  - one low start bit;
  - the data bits, least significant first, 8 of them when format bit 0 is 1 and 7 when it is 0;
  - a parity bit when format bit 2 is 1, even parity when format bit 1 is 1 and odd otherwise;
  - one high stop bit, or two when format bit 3 is 1.
- R3: Format bit 1 changes nothing on the line while format bit 2 is 0.
- R4: Bytes in the priority queue are loaded before any byte in the normal queue. `prio_pend` is high while the priority queue holds data.
- R5: The line byte is written with `reg_sel`=1, and its bit 0 enables the transmitter. While that bit is 0, no byte moves from either queue into the holding stage. After it is cleared, at most the character being shifted and the held character are sent.
- R6: `txq_empty` is high when the normal queue is empty. `shreg_empty` is high when neither the holding stage nor the shift register holds a character. `drained` is high when both are high.
- R7: When format bit 7 (CTS flow control) is 1 and `cts` is low, no new character starts. A character already being shifted completes unchanged.
- R8: While line bit 4 (break) is 1, `txd` is held low. When the bit is cleared, `txd` returns high.
- R9: While line bit 3 (loopback) is 1, the serial stream appears on `loop_out` and `txd` stays high. Otherwise `loop_out` stays high.
- R10: `dtr` follows line bit 2. `rts` follows line bit 1, except when format bit 6 (RTS toggle) is 1. In that case `rts` is high only while a character is held or being shifted.
- R11: A queue holds FIFO_DEPTH (normal) or PRIO_DEPTH (priority) bytes. `txq_full` or `prio_full` is high when the queue is full, and a push into a full queue is dropped.
- R12: The divisor is written with `reg_sel`=2. Each bit lasts (divisor+1)*BASE_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 format byte, 1 line byte, 2 divisor, 3 unused |
| reg_wdata | input | 16 | Register write data (low byte for control bytes) |
| fifo_push | input | 1 | Push a byte into the normal queue |
| fifo_din | input | 8 | Normal queue data |
| prio_push | input | 1 | Push a byte into the priority queue |
| prio_din | input | 8 | Priority queue data |
| cts | input | 1 | Clear-to-send, high when asserted |
| txd | output | 1 | Serial line, idle high |
| loop_out | output | 1 | Serial stream during loopback, otherwise high |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| txq_empty | output | 1 | Normal queue empty |
| shreg_empty | output | 1 | Holding stage and shift register empty |
| drained | output | 1 | Queue and shifting stages all empty |
| txq_full | output | 1 | Normal queue full |
| prio_full | output | 1 | Priority queue full |
| prio_pend | output | 1 | Priority data waiting |

## Verification
The framing is driven with one vector per format: 8N1, 7N1 with data bit 7 set, 8E1, 8O1, 7O2, and even-select without parity. Each vector separates data width, parity polarity, stop count and the ignored parity-select bit. Two divisors are used, which shows that bit timing scales with the divisor and is not fixed. Directed runs then cover several orderings:
- a priority byte pushed after two normal bytes, to show that it overtakes them;
- the enable cleared one character into a burst, to show the two-character drain bound;
- `cts` dropped in mid-character, to tell "finish current" from "abort" and from "start next";
- break, loopback, RTS toggle, and a queue pushed past full.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FRAME_W = 12;

    typedef struct packed {
        logic cts_fc;
        logic rts_tog;
        logic two_stop;
        logic par_en;
        logic par_even;
        logic data8;
    } fmt_t;

    typedef struct packed {
        logic brk;
        logic loop;
        logic dtr;
        logic rts;
        logic en;
    } linectl_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [3:0]         len;
    } frame_t;

    typedef enum logic [1:0] {
        SEL_FMT  = 2'd0,
        SEL_LINE = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_NONE = 2'd3
    } regsel_e;

    function automatic fmt_t decode_fmt(input logic [7:0] b);
        fmt_t f;
        f.cts_fc   = b[7];
        f.rts_tog  = b[6];
        f.two_stop = b[3];
        f.par_en   = b[2];
        f.par_even = b[1];
        f.data8    = b[0];
        return f;
    endfunction

    function automatic linectl_t decode_line(input logic [7:0] b);
        linectl_t l;
        l.brk  = b[4];
        l.loop = b[3];
        l.dtr  = b[2];
        l.rts  = b[1];
        l.en   = b[0];
        return l;
    endfunction

    function automatic frame_t build_frame(input fmt_t f, input logic [7:0] d);
        frame_t r;
        logic [7:0] dm;
        int idx;
        r.bits = '1;
        r.bits[0] = 1'b0;
        dm = f.data8 ? d : {1'b0, d[6:0]};
        idx = 1;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || f.data8) begin
                r.bits[idx] = dm[i];
                idx++;
            end
        end
        if (f.par_en) begin
            r.bits[idx] = f.par_even ? (^dm) : ~(^dm);
            idx++;
        end
        idx = idx + (f.two_stop ? 2 : 1);
        r.len = 4'(idx);
        return r;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 255,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R11: a push into a full queue leaves the occupancy alone
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(count));

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W    = 16,
    parameter int BASE_DIV = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_end
);
    localparam int PW = DIV_W + $clog2(BASE_DIV + 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] period_m1;

    assign period_m1 = (PW'(divisor) + PW'(1)) * PW'(BASE_DIV) - PW'(1);
    assign bit_end   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (restart)       cnt <= period_m1;
        else if (cnt == '0)     cnt <= period_m1;
        else                    cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_t       fmt,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    input  logic       cts,
    input  logic       bit_end,
    output logic       take,
    output logic       start,
    output logic       busy,
    output logic       hold_v,
    output logic       sout
);
    logic [7:0]         hold_d;
    logic [FRAME_W-1:0] sreg;
    logic [3:0]         left;
    frame_t             nxt;

    assign take  = src_valid && !hold_v;
    assign start = !busy && hold_v && (!fmt.cts_fc || cts);
    assign nxt   = build_frame(fmt, hold_d);
    assign sout  = busy ? sreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            busy   <= 1'b0;
            sreg   <= '1;
            left   <= '0;
        end else begin
            if (take) begin
                hold_v <= 1'b1;
                hold_d <= src_data;
            end
            if (start) begin
                hold_v <= 1'b0;
                busy   <= 1'b1;
                sreg   <= nxt.bits;
                left   <= nxt.len;
            end else if (busy && bit_end) begin
                sreg <= {1'b1, sreg[FRAME_W-1:1]};
                left <= left - 1'b1;
                if (left == 4'd1) busy <= 1'b0;
            end
        end
    end

    // R2: every character opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sout == 1'b0));

    // R7: with flow control on and CTS low, an idle shifter stays idle
    p_cts_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (fmt.cts_fc && !cts && !busy) |=> !busy);

    // R5: nothing enters the holding stage without an offered byte
    p_no_load_r5: assert property (@(posedge clk) disable iff (rst)
        (!src_valid && !hold_v) |=> !hold_v);

endmodule

// File: rtl/sertx_path.sv
module sertx_path
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 255,
    parameter int PRIO_DEPTH = 32,
    parameter int DIV_W      = 16,
    parameter int BASE_DIV   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [DIV_W-1:0] reg_wdata,
    input  logic             fifo_push,
    input  logic [7:0]       fifo_din,
    input  logic             prio_push,
    input  logic [7:0]       prio_din,
    input  logic             cts,
    output logic             txd,
    output logic             loop_out,
    output logic             dtr,
    output logic             rts,
    output logic             txq_empty,
    output logic             shreg_empty,
    output logic             drained,
    output logic             txq_full,
    output logic             prio_full
    ,
    output logic             prio_pend
);
    logic [7:0]       fmt_q, line_q;
    logic [DIV_W-1:0] div_q;
    fmt_t             fmt;
    linectl_t         lc;

    logic       f_empty, p_empty, f_pop, p_pop;
    logic [7:0] f_dout, p_dout;
    logic       src_valid, take, start, busy, hold_v, sout, bit_end, serial;
    logic [7:0] src_data;

    assign fmt = decode_fmt(fmt_q);
    assign lc  = decode_line(line_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= '0;
            line_q <= '0;
            div_q  <= '0;
        end else if (reg_we) begin
            case (regsel_e'(reg_sel))
                SEL_FMT:  fmt_q  <= reg_wdata[7:0];
                SEL_LINE: line_q <= reg_wdata[7:0];
                SEL_DIV:  div_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .push(fifo_push), .din(fifo_din),
        .pop(f_pop), .dout(f_dout), .empty(f_empty), .full(txq_full)
    );

    sertx_fifo #(.DEPTH(PRIO_DEPTH), .W(8)) u_prio (
        .clk(clk), .rst(rst), .push(prio_push), .din(prio_din),
        .pop(p_pop), .dout(p_dout), .empty(p_empty), .full(prio_full)
    );

    assign src_valid = lc.en && !(f_empty && p_empty);
    assign src_data  = p_empty ? f_dout : p_dout;
    assign p_pop     = take && !p_empty;
    assign f_pop     = take && p_empty;

    sertx_baud #(.DIV_W(DIV_W), .BASE_DIV(BASE_DIV)) u_baud (
        .clk(clk), .rst(rst), .restart(start), .divisor(div_q), .bit_end(bit_end)
    );

    sertx_shifter u_shift (
        .clk(clk), .rst(rst), .fmt(fmt), .src_valid(src_valid), .src_data(src_data),
        .cts(cts), .bit_end(bit_end), .take(take), .start(start),
        .busy(busy), .hold_v(hold_v), .sout(sout)
    );

    assign serial      = lc.brk ? 1'b0 : sout;
    assign txd         = lc.loop ? 1'b1 : serial;
    assign loop_out    = lc.loop ? serial : 1'b1;
    assign dtr         = lc.dtr;
    assign rts         = fmt.rts_tog ? (busy || hold_v) : lc.rts;
    assign txq_empty   = f_empty;
    assign shreg_empty = !busy && !hold_v;
    assign drained     = txq_empty && shreg_empty;
    assign prio_pend   = !p_empty;

    // R4: the normal queue only feeds the line when no priority byte waits
    p_prio_first_r4: assert property (@(posedge clk) disable iff (rst)
        f_pop |-> !prio_pend);

    // R9: in loopback the external line never leaves idle
    p_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        lc.loop |-> txd);

endmodule

// File: tb/sertx_path_tb.sv
module sertx_path_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 2;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [7:0]  data;
        logic [15:0] div;
        logic        r3;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h01, 8'hA5, 16'd3, 1'b0},
        '{8'h00, 8'hDA, 16'd3, 1'b0},
        '{8'h07, 8'h3C, 16'd1, 1'b0},
        '{8'h05, 8'h3C, 16'd3, 1'b0},
        '{8'h0C, 8'h41, 16'd1, 1'b0},
        '{8'h03, 8'hA5, 16'd3, 1'b1}
    };

    logic clk = 0, rst = 1;
    logic reg_we = 0;
    logic [1:0] reg_sel = 0;
    logic [15:0] reg_wdata = 0;
    logic fifo_push = 0, prio_push = 0;
    logic [7:0] fifo_din = 0, prio_din = 0;
    logic cts_ctl = 1, cts_kill = 0, kill_arm = 0;
    logic cts;
    logic txd, loop_out, dtr, rts, txq_empty, shreg_empty, drained, txq_full, prio_full, prio_pend;
    int checks = 0, fails = 0, falls = 0;
    logic prev_txd = 1;

    assign cts = cts_ctl && !cts_kill;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_path #(.BASE_DIV(BASE)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .fifo_push(fifo_push), .fifo_din(fifo_din), .prio_push(prio_push), .prio_din(prio_din),
        .cts(cts), .txd(txd), .loop_out(loop_out), .dtr(dtr), .rts(rts),
        .txq_empty(txq_empty), .shreg_empty(shreg_empty), .drained(drained),
        .txq_full(txq_full), .prio_full(prio_full), .prio_pend(prio_pend)
    );

    always @(negedge clk) begin
        if (prev_txd && !txd) falls <= falls + 1;
        prev_txd <= txd;
        if (kill_arm && !txd) cts_kill <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = val;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); fifo_push = 1; fifo_din = d;
        @(negedge clk); fifo_push = 0;
    endtask

    task automatic pushp(input logic [7:0] d);
        @(negedge clk); prio_push = 1; prio_din = d;
        @(negedge clk); prio_push = 0;
    endtask

    function automatic logic pick(input bit lp);
        return lp ? loop_out : txd;
    endfunction

    task automatic capture(input bit lp, input int n, input int bt, output logic [11:0] bits);
        bits = '1;
        @(negedge clk);
        while (pick(lp) !== 1'b0) @(negedge clk);
        repeat (bt/2) @(negedge clk);
        bits[0] = pick(lp);
        for (int k = 1; k < n; k++) begin
            repeat (bt) @(negedge clk);
            bits[k] = pick(lp);
        end
    endtask

    task automatic wait_drained();
        @(negedge clk);
        while (!drained) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic void exp_frame(input logic [7:0] cfg, input logic [7:0] d,
                                      output logic [11:0] f, output int len);
        int nd, ones;
        f = '1;
        f[0] = 1'b0;
        nd = cfg[0] ? 8 : 7;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            f[1+i] = d[i];
            if (d[i]) ones++;
        end
        len = 1 + nd;
        if (cfg[2]) begin
            f[len] = cfg[1] ? logic'(ones % 2) : logic'(1 - ones % 2);
            len++;
        end
        len = len + (cfg[3] ? 2 : 1);
    endfunction

    task automatic send_check(input string req, input logic [7:0] cfg, input logic [7:0] d,
                              input int bt, input bit lp);
        logic [11:0] e, g;
        int len;
        exp_frame(cfg, d, e, len);
        capture(lp, len, bt, g);
        chk(req, 32'(g), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] e8, g;
        int len, lowc, f0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", 32'(txd), 1);
        chk("R1 loop_out", 32'(loop_out), 1);
        chk("R1 dtr/rts", 32'({dtr, rts}), 0);
        chk("R1 empties", 32'({txq_empty, shreg_empty, drained}), 3'b111);
        chk("R1 fulls/pend", 32'({txq_full, prio_full, prio_pend}), 0);

        // R2 / R3 / R12: vector table of formats and divisors
        foreach (VECS[i]) begin
            wr(2'd0, {8'h00, VECS[i].cfg});
            wr(2'd2, VECS[i].div);
            wr(2'd1, 16'h0001);
            push(VECS[i].data);
            send_check(VECS[i].r3 ? "R3 parity-select ignored" : "R2 frame",
                       VECS[i].cfg, VECS[i].data, (int'(VECS[i].div) + 1) * BASE, 1'b0);
            wait_drained();
            wr(2'd1, 16'h0000);
        end
        // R3: even-select without parity equals plain 8N1 frame
        exp_frame(8'h01, 8'hA5, e8, len);
        exp_frame(8'h03, 8'hA5, g, lowc);
        chk("R3 same frame", 32'({g, 4'(lowc)}), 32'({e8, 4'(len)}));

        // R12: start bit length with divisor 5
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'd5);
        wr(2'd1, 16'h0001);
        push(8'hFF);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        lowc = 0;
        while (txd === 1'b0) begin lowc++; @(negedge clk); end
        chk("R12 bit time", 32'(lowc), 32'(6 * BASE));
        wait_drained();
        wr(2'd1, 16'h0000);

        // R6 status flags
        wr(2'd2, 16'd1);
        push(8'h12);
        @(negedge clk);
        chk("R6 queued disabled", 32'({txq_empty, shreg_empty, drained}), 3'b010);
        wr(2'd1, 16'h0001);
        repeat (2) @(negedge clk);
        chk("R6 shifting", 32'({txq_empty, shreg_empty, drained}), 3'b100);
        wait_drained();
        chk("R6 drained", 32'({txq_empty, shreg_empty, drained}), 3'b111);
        wr(2'd1, 16'h0000);

        // R5 drain bound after disable
        repeat (4) push(8'hFF);
        f0 = falls;
        @(negedge clk); reg_we = 1; reg_sel = 2'd1; reg_wdata = 16'h0001;
        @(negedge clk); reg_we = 0;
        while (txd !== 1'b0) @(negedge clk);
        reg_we = 1; reg_sel = 2'd1; reg_wdata = 16'h0000;
        @(negedge clk); reg_we = 0;
        repeat (200) @(negedge clk);
        chk("R5 frames after disable", 32'(falls - f0), 2);
        chk("R5 queue kept", 32'({txq_empty, shreg_empty}), 2'b01);
        wr(2'd1, 16'h0001);
        wait_drained();
        wr(2'd1, 16'h0000);

        // R4 priority ahead of normal bytes
        push(8'h11);
        push(8'h22);
        pushp(8'h99);
        @(negedge clk);
        chk("R4 pend", 32'(prio_pend), 1);
        wr(2'd1, 16'h0001);
        send_check("R4 first prio", 8'h01, 8'h99, 2 * BASE, 1'b0);
        send_check("R4 then normal", 8'h01, 8'h11, 2 * BASE, 1'b0);
        send_check("R4 then normal2", 8'h01, 8'h22, 2 * BASE, 1'b0);
        chk("R4 pend clear", 32'(prio_pend), 0);
        wait_drained();
        wr(2'd1, 16'h0000);

        // R7 CTS flow control
        wr(2'd0, 16'h0081);
        cts_ctl = 0;
        push(8'h55);
        wr(2'd1, 16'h0001);
        f0 = falls;
        repeat (100) @(negedge clk);
        chk("R7 held by cts", 32'({falls - f0, shreg_empty}), 0);
        cts_ctl = 1;
        send_check("R7 released", 8'h01, 8'h55, 2 * BASE, 1'b0);
        wait_drained();
        wr(2'd1, 16'h0000);
        push(8'h0F);
        push(8'hF0);
        kill_arm = 1;
        wr(2'd1, 16'h0001);
        send_check("R7 completes", 8'h01, 8'h0F, 2 * BASE, 1'b0);
        kill_arm = 0;
        f0 = falls;
        repeat (100) @(negedge clk);
        chk("R7 next blocked", 32'({falls - f0, shreg_empty, txd}), 1);
        cts_kill = 0;
        send_check("R7 next sent", 8'h01, 8'hF0, 2 * BASE, 1'b0);
        wait_drained();
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001);

        // R8 break
        wr(2'd1, 16'h0010);
        @(negedge clk);
        chk("R8 break low", 32'(txd), 0);
        wr(2'd1, 16'h0000);
        @(negedge clk);
        chk("R8 break released", 32'(txd), 1);

        // R9 loopback
        f0 = falls;
        wr(2'd1, 16'h0009);
        push(8'hC3);
        send_check("R9 loop stream", 8'h01, 8'hC3, 2 * BASE, 1'b1);
        wait_drained();
        chk("R9 txd idle", 32'(falls - f0), 0);
        wr(2'd1, 16'h0000);
        chk("R9 loop_out idle", 32'(loop_out), 1);

        // R10 modem lines
        wr(2'd1, 16'h0006);
        @(negedge clk);
        chk("R10 dtr rts", 32'({dtr, rts}), 2'b11);
        wr(2'd1, 16'h0004);
        @(negedge clk);
        chk("R10 rts off", 32'({dtr, rts}), 2'b10);
        wr(2'd0, 16'h0041);
        wr(2'd1, 16'h0001);
        push(8'h00);
        while (txd !== 1'b0) @(negedge clk);
        chk("R10 toggle active", 32'(rts), 1);
        wait_drained();
        chk("R10 toggle idle", 32'(rts), 0);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'd0);

        // R11 full queues and dropped pushes
        for (int i = 0; i < 256; i++) push(8'hFF);
        for (int i = 0; i < 33; i++) pushp(8'hFF);
        @(negedge clk);
        chk("R11 full flags", 32'({txq_full, prio_full}), 2'b11);
        f0 = falls;
        wr(2'd1, 16'h0001);
        wait_drained();
        chk("R11 dropped extra", 32'(falls - f0), 287);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule